// File: doc/BRIEF.md
# Programmable Event-to-Host Interrupt Router

This block collects a vector of system event lines and decides which host interrupt lines each event raises. An event counts as pending, and is routed, once software has enabled it. Each event names one channel in a per-event map, and each channel names one host line in a per-channel map. A host line rises when the global enable is on, the host line itself is enabled, and at least one enabled pending event reaches it through the two maps. Eight consecutive host lines (hosts 2 to 9) form an external interrupt bus for a remote processor.

Two local cores raise software events by writing a command word. Bit 5 of the word marks the command valid and bits 3:0 pick one of sixteen software lines. The two cores' lines are ORed together and enter the controller as system events 16 to 31. Each event has a polarity bit and a type bit. The type bit picks level tracking or a sticky edge capture that software acknowledges through an index register. A priority readback reports, for each host, which event is responsible for its request.

Top module: `evt_router`

## Requirements
- R1: After reset all host outputs and the external bus are 0 and the global enable is off. Every polarity bit reads 1 and every type bit reads 0. The host map is the identity, so host map register m (address 0x40+m) reads channel 4m+j in byte j.
- R2: When a core writes a word with bit 5 set, software line n (bits 3:0) goes high for exactly one cycle, starting the cycle after the write, and drives system event 16+n. A word with bit 5 clear produces no pulse. Writes from the two cores in the same cycle both take effect.
- R3: Channel map register k (address 0x10+k) holds the channel of event 4k+j in byte j. A channel value of 20 or more routes the event nowhere.
- R4: Host map register m (address 0x40+m) holds the host of channel 4m+j in byte j. A channel with a host value of 20 or more raises nothing.
- R5: Writing an event number to address 0x01 enables that event and to 0x02 disables it. Writing a host number to 0x03 enables that host line and to 0x04 disables it. A host line is never high unless it was enabled in the previous cycle. Out-of-range numbers change nothing.
- R6: Bit 0 of address 0x00 is the global enable. While it is 0, no host output is high.
- R7: Polarity register k (0x48+k) and type register k (0x50+k) hold bit b for event 32k+b. Polarity 1 means active high and 0 means active low. Type 0 means level and 1 means edge capture.
- R8: An edge-type event sets a sticky status bit on an active-going input edge, and the bit stays set until its number is written to address 0x05. An input held active after the clear does not set it again. A level-type event's status follows its polarity-corrected input, and a clear has no effect on it.
- R9: A host output changes one clock after the event status that causes it, and only when some event was pending in that cycle.
- R10: External bus bit i equals host output 2+i, for i from 0 to 7.
- R11: Reading 0x70+h returns 0x80000000 when no enabled pending event reaches host h. Otherwise it returns, in bits 7:0, the lowest-numbered event on the lowest-numbered pending channel that maps to h.
- R12: Read data appears one cycle after the read address. Address 0x58+k returns pending status, 0x60+k returns event enables (bit b for event 32k+b), and 0x68 returns the host enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysEvent | input | 160 | System event lines |
| core0WrEn | input | 1 | Core 0 command write strobe |
| core0WrData | input | 32 | Core 0 command word |
| core1WrEn | input | 1 | Core 1 command write strobe |
| core1WrData | input | 32 | Core 1 command word |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 8 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 8 | Register read address |
| regRdData | output | 32 | Registered read data |
| hostIrq | output | 20 | Host interrupt outputs |
| extIrq | output | 8 | Hosts 2 to 9 exported |

## Verification
The hardest case to set up is the contest between the two maps. Two events on different channels reach the same host, and the lower event number sits on the higher channel. The priority readback has to pick the lower channel's event, not the lower index. The stimulus programs one channel map register with mixed channels, moves one channel onto another's host through the host map, and raises both events before reading the report. A second hard case is the sticky status when the input stays active across a clear. The bench holds an edge-type input high, clears it, and watches that the host line drops and stays low.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

  localparam int NUM_EVENTS   = 160;
  localparam int NUM_CHANNELS = 20;
  localparam int NUM_HOSTS    = 20;
  localparam int NUM_CORES    = 2;
  localparam int SW_LINES     = 16;
  localparam int SW_BASE      = 16;
  localparam int EXT_FIRST    = 2;
  localparam int EXT_COUNT    = 8;

  localparam logic [7:0] ADDR_GLOBAL  = 8'h00;
  localparam logic [7:0] ADDR_EN_SET  = 8'h01;
  localparam logic [7:0] ADDR_EN_CLR  = 8'h02;
  localparam logic [7:0] ADDR_HEN_SET = 8'h03;
  localparam logic [7:0] ADDR_HEN_CLR = 8'h04;
  localparam logic [7:0] ADDR_ST_CLR  = 8'h05;
  localparam logic [7:0] CMAP_BASE    = 8'h10;
  localparam logic [7:0] HMAP_BASE    = 8'h40;
  localparam logic [7:0] POL_BASE     = 8'h48;
  localparam logic [7:0] TYPE_BASE    = 8'h50;
  localparam logic [7:0] RAW_BASE     = 8'h58;
  localparam logic [7:0] EN_RD_BASE   = 8'h60;
  localparam logic [7:0] HEN_RD       = 8'h68;
  localparam logic [7:0] PRIO_BASE    = 8'h70;

  typedef struct packed {
    logic        globalWr;
    logic        evtEnSet;
    logic        evtEnClr;
    logic        hostEnSet;
    logic        hostEnClr;
    logic        statClr;
    logic        chanMapWr;
    logic        hostMapWr;
    logic        polWr;
    logic        typeWr;
    logic [7:0]  slot;
    logic [31:0] data;
  } ctrlStrobes_t;

endpackage

// File: rtl/evt_router_swgen.sv
module evt_router_swgen #(
  parameter int NUM_CORES = 2,
  parameter int SW_LINES  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CORES-1:0]   wrEn,
  input  logic [NUM_CORES*6-1:0] wrCmd,
  output logic [SW_LINES-1:0]    swEvt
);
  // wrCmd per core: bit 5 valid, bit 4 unused, bits 3:0 line number
  logic [SW_LINES-1:0] pulseNext;
  logic [NUM_CORES-1:0] unusedBit4;

  always_comb begin
    pulseNext = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      unusedBit4[c] = wrCmd[6*c+4];
      if (wrEn[c] && wrCmd[6*c+5] && int'(wrCmd[6*c +: 4]) < SW_LINES)
        pulseNext[wrCmd[6*c +: 4]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swEvt <= '0;
    else       swEvt <= pulseNext;
  end
endmodule

// File: rtl/evt_router_ctrl.sv
module evt_router_ctrl
  import evt_router_pkg::*;
#(
  parameter int NUM_EVENTS   = evt_router_pkg::NUM_EVENTS,
  parameter int NUM_CHANNELS = evt_router_pkg::NUM_CHANNELS
) (
  input  logic         regWrEn,
  input  logic [7:0]   regWrAddr,
  input  logic [31:0]  regWrData,
  output ctrlStrobes_t strb
);
  localparam int CMAP_REGS = (NUM_EVENTS + 3) / 4;
  localparam int HMAP_REGS = (NUM_CHANNELS + 3) / 4;
  localparam int BIT_REGS  = (NUM_EVENTS + 31) / 32;

  function automatic logic inRange(input logic [7:0] a, input logic [7:0] base, input int cnt);
    return int'(a) >= int'(base) && int'(a) < int'(base) + cnt;
  endfunction

  always_comb begin
    strb      = '0;
    strb.data = regWrData;
    if (regWrEn) begin
      unique case (regWrAddr)
        ADDR_GLOBAL:  strb.globalWr  = 1'b1;
        ADDR_EN_SET:  strb.evtEnSet  = 1'b1;
        ADDR_EN_CLR:  strb.evtEnClr  = 1'b1;
        ADDR_HEN_SET: strb.hostEnSet = 1'b1;
        ADDR_HEN_CLR: strb.hostEnClr = 1'b1;
        ADDR_ST_CLR:  strb.statClr   = 1'b1;
        default: begin
          if (inRange(regWrAddr, CMAP_BASE, CMAP_REGS)) begin
            strb.chanMapWr = 1'b1;
            strb.slot      = regWrAddr - CMAP_BASE;
          end else if (inRange(regWrAddr, HMAP_BASE, HMAP_REGS)) begin
            strb.hostMapWr = 1'b1;
            strb.slot      = regWrAddr - HMAP_BASE;
          end else if (inRange(regWrAddr, POL_BASE, BIT_REGS)) begin
            strb.polWr = 1'b1;
            strb.slot  = regWrAddr - POL_BASE;
          end else if (inRange(regWrAddr, TYPE_BASE, BIT_REGS)) begin
            strb.typeWr = 1'b1;
            strb.slot   = regWrAddr - TYPE_BASE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evt_router_dp.sv
module evt_router_dp
  import evt_router_pkg::*;
#(
  parameter int NUM_EVENTS   = evt_router_pkg::NUM_EVENTS,
  parameter int NUM_CHANNELS = evt_router_pkg::NUM_CHANNELS,
  parameter int NUM_HOSTS    = evt_router_pkg::NUM_HOSTS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  logic [7:0]            rdAddr,
  output logic [31:0]           rdData,
  output logic [NUM_HOSTS-1:0]  hostIrq,
  output logic                  globalEnQ,
  output logic [NUM_HOSTS-1:0]  hostEnQ,
  output logic [NUM_EVENTS-1:0] pendQ
);
  localparam int CMAP_REGS = (NUM_EVENTS + 3) / 4;
  localparam int HMAP_REGS = (NUM_CHANNELS + 3) / 4;
  localparam int BIT_REGS  = (NUM_EVENTS + 31) / 32;
  localparam int BIT_W     = BIT_REGS * 32;

  logic [7:0] chanMap [NUM_EVENTS];
  logic [7:0] hostMap [NUM_CHANNELS];
  logic [NUM_EVENTS-1:0] evtEn, polHigh, typPulse, sticky, prevIn, corrIn, edgeSeen;
  logic [NUM_CHANNELS-1:0] chanHit;
  logic [7:0] chanIdx [NUM_CHANNELS];
  logic [NUM_HOSTS-1:0] hostHit;
  logic [7:0] hostIdx [NUM_HOSTS];
  logic [31:0] rdNext;
  logic [BIT_W-1:0] polPad, typPad, pendPad, enPad;

  // ---------------- configuration state ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEnQ <= 1'b0;
      hostEnQ   <= '0;
      evtEn     <= '0;
      polHigh   <= '1;
      typPulse  <= '0;
      for (int e = 0; e < NUM_EVENTS; e++)   chanMap[e] <= '0;
      for (int c = 0; c < NUM_CHANNELS; c++) hostMap[c] <= 8'(c);
    end else begin
      if (strb.globalWr) globalEnQ <= strb.data[0];
      for (int h = 0; h < NUM_HOSTS; h++) begin
        if (strb.hostEnSet && strb.data[7:0] == 8'(h)) hostEnQ[h] <= 1'b1;
        if (strb.hostEnClr && strb.data[7:0] == 8'(h)) hostEnQ[h] <= 1'b0;
      end
      for (int e = 0; e < NUM_EVENTS; e++) begin
        if (strb.evtEnSet && strb.data[7:0] == 8'(e)) evtEn[e] <= 1'b1;
        if (strb.evtEnClr && strb.data[7:0] == 8'(e)) evtEn[e] <= 1'b0;
        if (strb.polWr  && strb.slot == 8'(e / 32)) polHigh[e]  <= strb.data[e % 32];
        if (strb.typeWr && strb.slot == 8'(e / 32)) typPulse[e] <= strb.data[e % 32];
        if (strb.chanMapWr && strb.slot == 8'(e / 4))
          chanMap[e] <= strb.data[8*(e % 4) +: 8];
      end
      for (int c = 0; c < NUM_CHANNELS; c++)
        if (strb.hostMapWr && strb.slot == 8'(c / 4))
          hostMap[c] <= strb.data[8*(c % 4) +: 8];
    end
  end

  // ---------------- event status ----------------
  always_comb begin
    for (int e = 0; e < NUM_EVENTS; e++) begin
      corrIn[e]   = polHigh[e] ? evIn[e] : ~evIn[e];
      edgeSeen[e] = corrIn[e] & ~prevIn[e];
      pendQ[e]    = typPulse[e] ? (sticky[e] | edgeSeen[e]) : corrIn[e];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '1;
      sticky <= '0;
    end else begin
      prevIn <= corrIn;
      for (int e = 0; e < NUM_EVENTS; e++) begin
        if (!typPulse[e])
          sticky[e] <= 1'b0;
        else if (edgeSeen[e])
          sticky[e] <= 1'b1;
        else if (strb.statClr && strb.data[7:0] == 8'(e))
          sticky[e] <= 1'b0;
      end
    end
  end

  // ---------------- two-stage routing ----------------
  always_comb begin
    for (int c = 0; c < NUM_CHANNELS; c++) begin
      chanHit[c] = 1'b0;
      chanIdx[c] = '0;
      for (int e = NUM_EVENTS - 1; e >= 0; e--) begin
        if (evtEn[e] && pendQ[e] && chanMap[e] == 8'(c)) begin
          chanHit[c] = 1'b1;
          chanIdx[c] = 8'(e);
        end
      end
    end
  end

  always_comb begin
    for (int h = 0; h < NUM_HOSTS; h++) begin
      hostHit[h] = 1'b0;
      hostIdx[h] = '0;
      for (int c = NUM_CHANNELS - 1; c >= 0; c--) begin
        if (chanHit[c] && hostMap[c] == 8'(h)) begin
          hostHit[h] = 1'b1;
          hostIdx[h] = chanIdx[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostIrq <= '0;
    else       hostIrq <= {NUM_HOSTS{globalEnQ}} & hostEnQ & hostHit;
  end

  // ---------------- readback ----------------
  assign polPad  = BIT_W'(polHigh);
  assign typPad  = BIT_W'(typPulse);
  assign pendPad = BIT_W'(pendQ);
  assign enPad   = BIT_W'(evtEn);

  always_comb begin
    rdNext = '0;
    if (rdAddr == ADDR_GLOBAL) rdNext[0] = globalEnQ;
    if (rdAddr == HEN_RD)      rdNext[NUM_HOSTS-1:0] = hostEnQ;
    for (int e = 0; e < NUM_EVENTS; e++)
      if (rdAddr == 8'(int'(CMAP_BASE) + e / 4)) rdNext[8*(e % 4) +: 8] = chanMap[e];
    for (int c = 0; c < NUM_CHANNELS; c++)
      if (rdAddr == 8'(int'(HMAP_BASE) + c / 4)) rdNext[8*(c % 4) +: 8] = hostMap[c];
    for (int k = 0; k < BIT_REGS; k++) begin
      if (rdAddr == 8'(int'(POL_BASE) + k))   rdNext = polPad[32*k +: 32];
      if (rdAddr == 8'(int'(TYPE_BASE) + k))  rdNext = typPad[32*k +: 32];
      if (rdAddr == 8'(int'(RAW_BASE) + k))   rdNext = pendPad[32*k +: 32];
      if (rdAddr == 8'(int'(EN_RD_BASE) + k)) rdNext = enPad[32*k +: 32];
    end
    for (int h = 0; h < NUM_HOSTS; h++)
      if (rdAddr == 8'(int'(PRIO_BASE) + h))
        rdNext = hostHit[h] ? {24'h0, hostIdx[h]} : 32'h8000_0000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] sysEvent,
  input  logic                  core0WrEn,
  input  logic [31:0]           core0WrData,
  input  logic                  core1WrEn,
  input  logic [31:0]           core1WrData,
  input  logic                  regWrEn,
  input  logic [7:0]            regWrAddr,
  input  logic [31:0]           regWrData,
  input  logic [7:0]            regRdAddr,
  output logic [31:0]           regRdData,
  output logic [NUM_HOSTS-1:0]  hostIrq,
  output logic [EXT_COUNT-1:0]  extIrq
);
  ctrlStrobes_t          strb;
  logic [SW_LINES-1:0]   swEvt;
  logic [NUM_EVENTS-1:0] evIn;
  logic                  globalEnQ;
  logic [NUM_HOSTS-1:0]  hostEnQ;
  logic [NUM_EVENTS-1:0] pendQ;
  logic [51:0]           unusedCoreBits;

  assign unusedCoreBits = {core0WrData[31:6], core1WrData[31:6]};

  evt_router_swgen #(.NUM_CORES(NUM_CORES), .SW_LINES(SW_LINES)) i_swgen (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  ({core1WrEn, core0WrEn}),
    .wrCmd ({core1WrData[5:0], core0WrData[5:0]}),
    .swEvt (swEvt)
  );

  assign evIn = sysEvent | (NUM_EVENTS'(swEvt) << SW_BASE);

  evt_router_ctrl #(.NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS)) i_ctrl (
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  evt_router_dp #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS), .NUM_HOSTS(NUM_HOSTS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evIn      (evIn),
    .rdAddr    (regRdAddr),
    .rdData    (regRdData),
    .hostIrq   (hostIrq),
    .globalEnQ (globalEnQ),
    .hostEnQ   (hostEnQ),
    .pendQ     (pendQ)
  );

  assign extIrq = hostIrq[EXT_FIRST +: EXT_COUNT];
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int NE  = 160,
  parameter int NH  = 20,
  parameter int SWL = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          c0Valid,
  input logic          c1Valid,
  input logic [SWL-1:0] swEvt,
  input logic          globalEnQ,
  input logic [NH-1:0] hostEnQ,
  input logic [NE-1:0] pendQ,
  input logic [NH-1:0] hostIrq
);
  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) a_r1_reset_quiet: assert (hostIrq == '0);
  end

  // R2: no software line pulses without a valid command the cycle before
  a_r2_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !(c0Valid || c1Valid) |=> swEvt == '0);

  // R5: a host line needs its own enable from the previous cycle
  a_r5_host_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> (hostIrq & ~$past(hostEnQ)) == '0);

  // R6: any host output needs the global enable from the previous cycle
  a_r6_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> $past(globalEnQ));

  // R9: a host output needs some pending event one cycle earlier
  a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> $past(pendQ != '0));
endmodule

bind evt_router evt_router_chk #(
  .NE(evt_router_pkg::NUM_EVENTS), .NH(evt_router_pkg::NUM_HOSTS), .SWL(evt_router_pkg::SW_LINES)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .c0Valid   (core0WrEn & core0WrData[5]),
  .c1Valid   (core1WrEn & core1WrData[5]),
  .swEvt     (swEvt),
  .globalEnQ (globalEnQ),
  .hostEnQ   (hostEnQ),
  .pendQ     (pendQ),
  .hostIrq   (hostIrq)
);

// File: tb/test_evt_router.sv
module test_evt_router;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [159:0] sysEvent = '0;
  logic         core0WrEn = 1'b0, core1WrEn = 1'b0;
  logic [31:0]  core0WrData = '0, core1WrData = '0;
  logic         regWrEn = 1'b0;
  logic [7:0]   regWrAddr = '0, regRdAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [19:0]  hostIrq;
  logic [7:0]   extIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  evt_router i_evt_router (
    .clk(clk), .rstN(rstN), .sysEvent(sysEvent),
    .core0WrEn(core0WrEn), .core0WrData(core0WrData),
    .core1WrEn(core1WrEn), .core1WrData(core1WrData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .hostIrq(hostIrq), .extIrq(extIrq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regRdAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic coreWrite(input bit c0, input logic [31:0] d0, input bit c1, input logic [31:0] d1);
    core0WrEn = c0; core0WrData = d0; core1WrEn = c1; core1WrData = d1;
    @(negedge clk);
    core0WrEn = 1'b0; core1WrEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 hostIrq", 32'(hostIrq), 32'h0);
    chk("R1 extIrq", 32'(extIrq), 32'h0);
    regRead(8'h00, v); chk("R1 global", v, 32'h0);
    regRead(8'h48, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    regRead(8'h50, v); chk("R1 type", v, 32'h0);
    regRead(8'h40, v); chk("R1 hostmap0", v, 32'h0302_0100);
    regRead(8'h44, v); chk("R1 hostmap4", v, 32'h1312_1110);
  endtask

  task automatic testLevelRoute();
    logic [31:0] v;
    regWrite(8'h1A, 32'h0000_0004);
    regRead(8'h1A, v); chk("R3 chanmap readback", v, 32'h0000_0004);
    regWrite(8'h01, 32'd40);
    regWrite(8'h03, 32'd4);
    regWrite(8'h00, 32'd1);
    sysEvent[40] = 1'b1;
    chk("R9 no output before edge", 32'(hostIrq), 32'h0);
    step(1);
    chk("R9 R3 host4 raised", 32'(hostIrq), 32'h0_0010);
    chk("R10 ext bit2", 32'(extIrq), 32'h04);
    regRead(8'h59, v); chk("R12 raw status", v, 32'h0000_0100);
  endtask

  task automatic testGlobal();
    regWrite(8'h00, 32'd0);
    step(1);
    chk("R6 global off", 32'(hostIrq), 32'h0);
    regWrite(8'h00, 32'd1);
    step(1);
    chk("R6 global on", 32'(hostIrq), 32'h0_0010);
  endtask

  task automatic testHostMap();
    regWrite(8'h41, 32'h0706_0507);
    regWrite(8'h03, 32'd7);
    step(1);
    chk("R4 host7 via map", 32'(hostIrq), 32'h0_0080);
    chk("R10 ext bit5", 32'(extIrq), 32'h20);
    regWrite(8'h41, 32'h0706_0520);
    step(1);
    chk("R4 out-of-range host", 32'(hostIrq), 32'h0);
    regWrite(8'h41, 32'h0706_0504);
    regWrite(8'h04, 32'd7);
    sysEvent[40] = 1'b0;
    step(1);
    chk("R8 level drops", 32'(hostIrq), 32'h0);
  endtask

  task automatic testPolarity();
    regWrite(8'h1A, 32'h0000_0404);
    regWrite(8'h49, 32'hFFFF_FDFF);
    regWrite(8'h01, 32'd41);
    step(1);
    chk("R7 active-low idle input", 32'(hostIrq), 32'h0_0010);
    sysEvent[41] = 1'b1;
    step(1);
    chk("R7 active-low driven", 32'(hostIrq), 32'h0);
    sysEvent[41] = 1'b0;
    regWrite(8'h02, 32'd41);
    regWrite(8'h49, 32'hFFFF_FFFF);
    step(1);
  endtask

  task automatic testSticky();
    logic [31:0] v;
    regWrite(8'h51, 32'h0000_0400);
    regWrite(8'h1A, 32'h0004_0404);
    regWrite(8'h01, 32'd42);
    step(1);
    sysEvent[42] = 1'b1;
    step(1);
    sysEvent[42] = 1'b0;
    chk("R8 edge captured", 32'(hostIrq), 32'h0_0010);
    step(3);
    chk("R8 sticky holds", 32'(hostIrq), 32'h0_0010);
    regRead(8'h59, v); chk("R8 raw sticky", v, 32'h0000_0400);
    regWrite(8'h05, 32'd42);
    step(1);
    chk("R8 cleared", 32'(hostIrq), 32'h0);
    sysEvent[42] = 1'b1;
    step(2);
    chk("R8 held input captured", 32'(hostIrq), 32'h0_0010);
    regWrite(8'h05, 32'd42);
    step(2);
    chk("R8 no retrigger while held", 32'(hostIrq), 32'h0);
    sysEvent[42] = 1'b0;
    sysEvent[40] = 1'b1;
    step(1);
    regWrite(8'h05, 32'd40);
    step(2);
    chk("R8 clear ignored for level", 32'(hostIrq), 32'h0_0010);
    sysEvent[40] = 1'b0;
    step(1);
    chk("R8 level released", 32'(hostIrq), 32'h0);
  endtask

  task automatic testSoftware();
    logic [31:0] v;
    regWrite(8'h14, 32'h0900_0000);
    regWrite(8'h01, 32'd19);
    regWrite(8'h03, 32'd9);
    coreWrite(1'b1, 32'h23, 1'b0, 32'h0);
    chk("R2 pulse not yet routed", 32'(hostIrq), 32'h0);
    step(1);
    chk("R2 core0 pulse", 32'(hostIrq), 32'h0_0200);
    chk("R10 ext bit7", 32'(extIrq), 32'h80);
    step(1);
    chk("R2 pulse one cycle", 32'(hostIrq), 32'h0);
    coreWrite(1'b0, 32'h0, 1'b1, 32'h03);
    step(1);
    chk("R2 invalid word no pulse", 32'(hostIrq), 32'h0);
    regWrite(8'h50, 32'h000C_0000);
    regWrite(8'h14, 32'h0909_0000);
    regWrite(8'h01, 32'd18);
    coreWrite(1'b0, 32'h0, 1'b1, 32'h03);
    step(2);
    regRead(8'h58, v); chk("R2 invalid word leaves status", v, 32'h0);
    coreWrite(1'b1, 32'h23, 1'b1, 32'h22);
    step(1);
    chk("R2 both cores", 32'(hostIrq), 32'h0_0200);
    regRead(8'h58, v); chk("R2 both lines latched", v, 32'h000C_0000);
    regRead(8'h79, v); chk("R11 lowest event", v, 32'h0000_0012);
    regWrite(8'h05, 32'd18);
    regWrite(8'h05, 32'd19);
    step(1);
    chk("R8 software status cleared", 32'(hostIrq), 32'h0);
  endtask

  task automatic testPriority();
    logic [31:0] v;
    sysEvent[40] = 1'b1;
    regWrite(8'h1A, 32'h0304_0404);
    regWrite(8'h40, 32'h0402_0100);
    regWrite(8'h01, 32'd43);
    regRead(8'h74, v); chk("R11 single event", v, 32'h0000_0028);
    regRead(8'h75, v); chk("R11 none pending", v, 32'h8000_0000);
    sysEvent[43] = 1'b1;
    regRead(8'h74, v); chk("R11 lower channel wins", v, 32'h0000_002B);
    sysEvent[43] = 1'b0;
    regWrite(8'h40, 32'h0302_0100);
  endtask

  task automatic testIndexRanges();
    logic [31:0] v;
    regRead(8'h61, v); chk("R12 enable readback", v, 32'h0000_0D00);
    regWrite(8'h01, 32'd200);
    regRead(8'h61, v); chk("R5 out-of-range event", v, 32'h0000_0D00);
    regRead(8'h68, v); chk("R12 host enable readback", v, 32'h0000_0210);
    regWrite(8'h03, 32'd25);
    regRead(8'h68, v); chk("R5 out-of-range host", v, 32'h0000_0210);
    regWrite(8'h1B, 32'h0000_0020);
    regWrite(8'h01, 32'd44);
    sysEvent[40] = 1'b0;
    sysEvent[44] = 1'b1;
    step(2);
    chk("R3 out-of-range channel", 32'(hostIrq), 32'h0);
    sysEvent[44] = 1'b0;
    sysEvent[40] = 1'b1;
    step(1);
    chk("R5 host4 active", 32'(hostIrq), 32'h0_0010);
    regWrite(8'h04, 32'd4);
    step(1);
    chk("R5 host disabled", 32'(hostIrq), 32'h0);
    regWrite(8'h02, 32'd40);
    regRead(8'h61, v); chk("R5 event disabled", v, 32'h0000_1C00);
    sysEvent[40] = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testLevelRoute();
    testGlobal();
    testHostMap();
    testPolarity();
    testSticky();
    testSoftware();
    testPriority();
    testIndexRanges();
    step(2);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    finishRun();
  end
endmodule